// File: doc/BRIEF.md
# Dual-Clock Handshaked FIFO Channel

This block moves data words in one direction between two clock domains that share no phase or frequency relationship. A producer in the write clock domain offers one word per handshake, and a consumer in the read clock domain takes one word per handshake. Inside, the words sit in a small register array. Two pointers track the array, and each is passed into the opposite domain in Gray code through a two-stage flip-flop synchronizer, so no user-visible signal ever samples an unsynchronized level.

Both edges of the channel use level handshakes and not raw status flags. The producer raises its request while the ready line is high and keeps it up. Ready falls the cycle after the word is accepted. Ready comes back only after the request has been lowered and free space exists. The read side mirrors this with its own request and availability line. The depth is a power-of-two parameter. A depth of one is legal: it trades throughput for area and keeps the same protocol.

Top module: `xclk_hs_fifo`

## Requirements
- R1: While held in reset, and directly after each domain leaves reset, `wr_ready` is 1 and `rd_avail` is 0.
- R2: When `wr_push` is 1 and `wr_ready` is 1 at a write clock edge, the word on `wr_data` is stored and `wr_ready` is 0 after that edge. A request held high over many cycles stores exactly one word, and `wr_ready` stays low until `wr_push` returns to 0.
- R3: Once DEPTH words are stored and none has been read, `wr_ready` stays 0. A request raised and dropped during this time stores nothing. The number of stored words never exceeds DEPTH.
- R4: Within a few read clock cycles after a word is stored, `rd_avail` becomes 1 (two synchronizer stages plus one register).
- R5: While `rd_avail` is 1, `rd_data` shows the oldest unread word. When `rd_pop` is 1 with `rd_avail` 1 at a read clock edge, that word is removed, and `rd_avail` is 0 after that edge until `rd_pop` returns to 0.
- R6: With no unread word, `rd_avail` stays 0 for as long as nothing new is written.
- R7: With both clocks running at unrelated rates and random request timing, the words arrive in write order, none lost and none repeated.
- R8: With DEPTH = 1, R1 to R7 still hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain reset, active low |
| wr_push | input | 1 | Producer request level |
| wr_data | input | DW | Word offered by the producer |
| wr_ready | output | 1 | Channel can accept a word |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain reset, active low |
| rd_pop | input | 1 | Consumer request level |
| rd_data | output | DW | Oldest unread word |
| rd_avail | output | 1 | A word is ready to be taken |

## Verification
A corrupted pointer shows up at `rd_data` as a word that is out of order, repeated or missing. This appears at the next read handshake after the fault, because each word taken is compared against an ordered model queue. A pointer that crosses domains wrongly shows as a false full or empty state. That makes `wr_ready` or `rd_avail` wrong within a few cycles of the other domain's clock. A handshake flag stuck high freezes one side, and the bounded waits catch this as a failure. Each test runs on a four-entry channel and again on a one-entry channel, because the single-entry case makes full and empty alternate on every word.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    // binary to reflected Gray code
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // reflected Gray code back to binary: xor of all right shifts
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int i = 1; i < 32; i++) begin
            b = b ^ (g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/xfifo_sync2.sv
module xfifo_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside
    import xfifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LW = $clog2(DEPTH),
    localparam int PW = LW + 1,
    localparam int AW = (LW > 0) ? LW : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] rgray_s,
    output logic          ready,
    output logic          wen,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          held;
    } wst_t;

    wst_t          st_d, st_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] fill;
    logic          full;
    logic          take_item;

    always_comb begin
        rbin      = PW'(from_gray(32'(rgray_s)));
        fill      = st_q.bin - rbin;
        full      = (fill == PW'(DEPTH));
        take_item = push && !st_q.held && !full;
        st_d      = st_q;
        if (take_item) begin
            st_d.bin  = st_q.bin + PW'(1);
            st_d.gray = PW'(to_gray(32'(st_d.bin)));
            st_d.held = 1'b1;
        end else if (!push) begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = !full && !st_q.held;
    assign wen   = take_item;
    assign wgray = st_q.gray;

    generate
        if (LW > 0) begin : g_addr
            assign waddr = st_q.bin[AW-1:0];
        end else begin : g_addr1
            assign waddr = '0;
        end
    endgenerate

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        take_item |=> !ready);
    a_r2_one_per_level: assert property (@(posedge clk) disable iff (!rst_n)
        take_item |=> !take_item);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(DEPTH));
    a_r7_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.gray ^ $past(st_q.gray)));
endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside
    import xfifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LW = $clog2(DEPTH),
    localparam int PW = LW + 1,
    localparam int AW = (LW > 0) ? LW : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic [PW-1:0] wgray_s,
    output logic          avail,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          held;
    } rst_t;

    rst_t          st_d, st_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] fill;
    logic          empty;
    logic          give_item;

    always_comb begin
        wbin      = PW'(from_gray(32'(wgray_s)));
        fill      = wbin - st_q.bin;
        empty     = (fill == '0);
        give_item = pop && !st_q.held && !empty;
        st_d      = st_q;
        if (give_item) begin
            st_d.bin  = st_q.bin + PW'(1);
            st_d.gray = PW'(to_gray(32'(st_d.bin)));
            st_d.held = 1'b1;
        end else if (!pop) begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avail = !empty && !st_q.held;
    assign rgray = st_q.gray;

    generate
        if (LW > 0) begin : g_addr
            assign raddr = st_q.bin[AW-1:0];
        end else begin : g_addr1
            assign raddr = '0;
        end
    endgenerate

    a_r5_avail_drops: assert property (@(posedge clk) disable iff (!rst_n)
        give_item |=> !avail);
    a_r5_one_per_level: assert property (@(posedge clk) disable iff (!rst_n)
        give_item |=> !give_item);
    a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(DEPTH));
    a_r7_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.gray ^ $past(st_q.gray)));
endmodule

// File: rtl/xclk_hs_fifo.sv
module xclk_hs_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_push,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_pop,
    output logic [DW-1:0] rd_data,
    output logic          rd_avail
);
    localparam int LW = $clog2(DEPTH);
    localparam int PW = LW + 1;
    localparam int AW = (LW > 0) ? LW : 1;

    logic [PW-1:0] wgray, wgray_s;
    logic [PW-1:0] rgray, rgray_s;
    logic          wen;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] mem_q [DEPTH];

    xfifo_wside #(.DEPTH(DEPTH)) u_wside (
        .clk(wr_clk), .rst_n(wr_rst_n), .push(wr_push), .rgray_s(rgray_s),
        .ready(wr_ready), .wen(wen), .waddr(waddr), .wgray(wgray)
    );

    xfifo_rside #(.DEPTH(DEPTH)) u_rside (
        .clk(rd_clk), .rst_n(rd_rst_n), .pop(rd_pop), .wgray_s(wgray_s),
        .avail(rd_avail), .raddr(raddr), .rgray(rgray)
    );

    xfifo_sync2 #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .din(wgray), .dout(wgray_s)
    );

    xfifo_sync2 #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .din(rgray), .dout(rgray_s)
    );

    always_ff @(posedge wr_clk) begin
        if (wen) mem_q[waddr] <= wr_data;
    end

    assign rd_data = mem_q[raddr];
endmodule

// File: tb/xclk_hs_fifo_tb.sv
`timescale 1ns/1ps
module xclk_hs_fifo_tb_top;
    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_rst_n;
    logic       rd_rst_n;
    logic       push   [2];
    logic       pop    [2];
    logic [7:0] wdata  [2];
    logic       wready [2];
    logic       ravail [2];
    logic [7:0] rdata  [2];

    logic [7:0] q0[$];
    logic [7:0] q1[$];
    int tests = 0;
    int fails = 0;
    int rx_cnt[2];
    int tx_cnt[2];

    always #5    wr_clk = ~wr_clk;
    always #7.3  rd_clk = ~rd_clk;

    xclk_hs_fifo #(.DEPTH(4), .DW(8)) dut_i (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_push(push[0]), .wr_data(wdata[0]),
        .wr_ready(wready[0]), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_pop(pop[0]),
        .rd_data(rdata[0]), .rd_avail(ravail[0])
    );

    xclk_hs_fifo #(.DEPTH(1), .DW(8)) dut_one_i (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_push(push[1]), .wr_data(wdata[1]),
        .wr_ready(wready[1]), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_pop(pop[1]),
        .rd_data(rdata[1]), .rd_avail(ravail[1])
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic qput(input int s, input logic [7:0] v);
        if (s == 0) q0.push_back(v);
        else        q1.push_back(v);
        tx_cnt[s]++;
    endtask

    task automatic qget(input int s, output logic [7:0] v, output bit ok);
        ok = 1'b0;
        v  = 8'h00;
        if (s == 0 && q0.size() > 0) begin v = q0.pop_front(); ok = 1'b1; end
        if (s == 1 && q1.size() > 0) begin v = q1.pop_front(); ok = 1'b1; end
    endtask

    // one producer handshake; R2 checked on the cycle after acceptance
    task automatic send(input int s, input logic [7:0] v);
        @(negedge wr_clk);
        while (!wready[s]) @(negedge wr_clk);
        wdata[s] = v;
        push[s]  = 1'b1;
        @(negedge wr_clk);
        chk(wready[s] == 1'b0, "R2", "ready after accept", int'(wready[s]), 0);
        push[s] = 1'b0;
        qput(s, v);
    endtask

    // one consumer handshake; data order (R7, R8 on lane 1) and R5 drop
    task automatic recv(input int s);
        logic [7:0] e;
        bit ok;
        @(negedge rd_clk);
        while (!ravail[s]) @(negedge rd_clk);
        qget(s, e, ok);
        chk(ok && rdata[s] == e, (s == 1) ? "R8" : "R7", "rd_data vs oldest word",
            int'(rdata[s]), int'(e));
        pop[s] = 1'b1;
        @(negedge rd_clk);
        chk(ravail[s] == 1'b0, "R5", "avail after take", int'(ravail[s]), 0);
        pop[s] = 1'b0;
        rx_cnt[s]++;
    endtask

    task automatic lane(input int s, input int depth);
        logic [7:0] base;
        base = (s == 0) ? 8'h10 : 8'h80;
        // fill to capacity with no reads
        for (int i = 0; i < depth; i++) send(s, base + 8'(i));
        repeat (8) @(negedge wr_clk);
        chk(wready[s] == 1'b0, "R3", "ready while full", int'(wready[s]), 0);
        @(negedge rd_clk);
        chk(ravail[s] == 1'b1, "R4", "avail after writes", int'(ravail[s]), 1);
        // request while full, dropped before space frees: must store nothing
        @(negedge wr_clk);
        wdata[s] = 8'hEE;
        push[s]  = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge wr_clk);
            chk(wready[s] == 1'b0, "R3", "ready with push while full", int'(wready[s]), 0);
        end
        push[s] = 1'b0;
        for (int i = 0; i < depth; i++) recv(s);
        repeat (8) @(negedge rd_clk);
        chk(ravail[s] == 1'b0, "R3", "no word stored while full", int'(ravail[s]), 0);
        chk(ravail[s] == 1'b0, "R6", "avail while empty", int'(ravail[s]), 0);
        // held request stores exactly one word
        @(negedge wr_clk);
        while (!wready[s]) @(negedge wr_clk);
        wdata[s] = 8'h5A;
        push[s]  = 1'b1;
        repeat (6) @(negedge wr_clk);
        chk(wready[s] == 1'b0, "R2", "ready while push held", int'(wready[s]), 0);
        push[s] = 1'b0;
        qput(s, 8'h5A);
        recv(s);
        repeat (8) @(negedge rd_clk);
        chk(ravail[s] == 1'b0, "R2", "one word per held push", int'(ravail[s]), 0);
        // empty then one write: avail must rise within bounded read cycles
        send(s, 8'hC3);
        begin
            int n;
            n = 0;
            @(negedge rd_clk);
            while (!ravail[s] && n < 6) begin @(negedge rd_clk); n++; end
            chk(ravail[s] == 1'b1, "R4", "read cycles to avail", n, 5);
        end
        recv(s);
        // random concurrent traffic
        fork
            begin
                for (int i = 0; i < 120; i++) begin
                    repeat ($urandom_range(0, 3)) @(negedge wr_clk);
                    send(s, 8'($urandom_range(0, 255)));
                end
            end
            begin
                for (int i = 0; i < 120; i++) begin
                    repeat ($urandom_range(0, 4)) @(negedge rd_clk);
                    recv(s);
                end
            end
        join
        repeat (8) @(negedge rd_clk);
        chk(ravail[s] == 1'b0 && rx_cnt[s] == tx_cnt[s], (s == 1) ? "R8" : "R7",
            "words received vs sent", rx_cnt[s], tx_cnt[s]);
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        for (int s = 0; s < 2; s++) begin
            push[s] = 1'b0; pop[s] = 1'b0; wdata[s] = 8'h00;
            rx_cnt[s] = 0; tx_cnt[s] = 0;
        end
        repeat (3) @(negedge wr_clk);
        for (int s = 0; s < 2; s++) begin
            chk(wready[s] == 1'b1, "R1", "ready in reset", int'(wready[s]), 1);
            chk(ravail[s] == 1'b0, "R1", "avail in reset", int'(ravail[s]), 0);
        end
        wr_rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
        rd_rst_n = 1'b1;
        repeat (2) @(negedge wr_clk);
        for (int s = 0; s < 2; s++) begin
            chk(wready[s] == 1'b1, "R1", "ready after reset", int'(wready[s]), 1);
            chk(ravail[s] == 1'b0, "R1", "avail after reset", int'(ravail[s]), 0);
        end
        lane(0, 4);
        lane(1, 1);
        finish_up();
    end
endmodule